// File: doc/BRIEF.md
# Streaming Nibble Dot-Product Engine

This block computes one column of a kernel matrix. A reference vector sits in an on-chip memory. A long stream of candidate vectors comes in, and the block returns one dot product per candidate. Each input beat is 128 bits wide, made of four 32-bit words. A beat carries 32 signed 4-bit components, and those components feed 32 multiply lanes in lock-step. A pipelined adder tree folds the 32 lane products into a 48-bit running sum. When a vector ends, the sum is shifted right by a programmable amount and clamped to a signed 16-bit value.

Finished results go into one of two result banks of four entries each. While one bank fills, the other is offered to the consumer, and the two banks swap roles. The input is a valid/ready stream. When both banks hold undrained results, the engine drops ready and waits.

Vector length and shift are set through `vecChunksM1` and `shiftAmt`. These two inputs must stay stable from the first beat of a vector until its result has been stored.

Top module: `nibbleDotEngine`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` is 0 and `outBank` is 0.
- R2: Component j of a beat is held in bits [4j+3:4j], and the value is signed two's complement (4'h8 is -8, 4'hF is -1). Beat c of a vector is multiplied lane by lane with the reference chunk written at `refAddr` = c.
- R3: A vector is `vecChunksM1`+1 beats long. Its products are summed at 48-bit width, and the sum is arithmetically shifted right by `shiftAmt`, which rounds toward minus infinity.
- R4: A shifted sum above 32767 is reported as 32767, and one below -32768 is reported as -32768.
- R5: Cycles with `inValid` low between the beats of a vector do not change its result.
- R6: Results fill four-entry banks in arrival order, starting with bank 0, and the two banks alternate. A bank is offered through `outValid`/`outData` in entry order, and `outBank` names the bank being drained.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outBank` hold their values.
- R8: When both banks hold claimed results that are not yet drained, `inReady` is 0. It returns to 1 once the older bank has been drained completely.
- R9: A bank that is only partly filled is not offered: `outValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refWe | input | 1 | Write strobe for the reference memory |
| refAddr | input | 5 | Reference chunk index |
| refData | input | 128 | Reference chunk, 32 packed 4-bit components |
| vecChunksM1 | input | 5 | Vector length in beats, minus one |
| shiftAmt | input | 6 | Right shift applied before clamping |
| inValid | input | 1 | Candidate beat valid |
| inReady | output | 1 | Engine can take a beat |
| inData | input | 128 | Candidate beat, 32 packed 4-bit components |
| outValid | output | 1 | A result from a full bank is offered |
| outReady | input | 1 | Consumer takes the offered result |
| outData | output | 16 | Clamped signed result |
| outBank | output | 1 | Bank the offered result comes from |

## Verification
The bench covers the following corner cases, each with the wrong output it would catch:
- **Clamping.** Sums of +65536 and -57344 must clamp at both 16-bit limits. A design that drops the upper bits would return 0 or a wrapped value instead.
- **Arithmetic shift.** A negative sum shifted by 6 must round toward minus infinity. A logical shift would return a large positive number, and a truncating divide would give -1 instead of -2.
- **Signed nibble decoding.** One vector is made of nibbles that mix signs. An unsigned decode changes its result from 42 to a much larger value.
- **Gaps and back-pressure.** Idle cycles between beats must not change results, so a design that clears or double-counts its accumulator on bubbles shows up. With both banks full, a design that keeps accepting beats overwrites results that have not been drained. A design that offers a bank early raises `outValid` while the bank is still partly filled.

// File: rtl/nde_pkg.sv
package nde_pkg;
  // Per-beat strobes from the control to the datapath
  typedef struct packed {
    logic take;   // a beat is accepted this cycle
    logic first;  // the beat is chunk 0 of a vector
    logic last;   // the beat is the final chunk of a vector
  } strobe_t;
endpackage

// File: rtl/nde_ctrl.sv
module nde_ctrl
  import nde_pkg::*;
#(
  parameter int REF_DEPTH = 32,
  parameter int BUF_DEPTH = 4,
  localparam int REF_AW = $clog2(REF_DEPTH),
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [REF_AW-1:0] vecChunksM1,
  input  logic              outReady,
  input  logic              resWrite,
  output logic              inReady,
  output strobe_t           strb,
  output logic [REF_AW-1:0] chunkIdx,
  output logic              wrBank,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              rdBank,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              outValid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_DEPTH - 1);

  logic             claimBank;
  logic [IDX_W-1:0] claimCnt;
  logic [1:0]       bankFull;   // every slot of the bank has been claimed
  logic [1:0]       bankDone;   // every slot of the bank has been written
  logic             pop;
  logic             claimWrap;
  logic             writeWrap;
  logic             drainWrap;

  assign inReady   = !bankFull[claimBank];
  assign strb.take = inValid && inReady;
  assign strb.first = (chunkIdx == '0);
  assign strb.last  = (chunkIdx == vecChunksM1);

  assign outValid  = bankDone[rdBank];
  assign pop       = outValid && outReady;
  assign claimWrap = strb.take && strb.last && (claimCnt == LAST_IDX);
  assign writeWrap = resWrite && (wrIdx == LAST_IDX);
  assign drainWrap = pop && (rdIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chunkIdx  <= '0;
      claimBank <= 1'b0;
      claimCnt  <= '0;
      wrBank    <= 1'b0;
      wrIdx     <= '0;
      rdBank    <= 1'b0;
      rdIdx     <= '0;
      bankFull  <= '0;
      bankDone  <= '0;
    end else begin
      if (strb.take) begin
        chunkIdx <= strb.last ? '0 : chunkIdx + 1'b1;
      end
      if (strb.take && strb.last) begin
        claimCnt <= claimWrap ? '0 : claimCnt + 1'b1;
      end
      if (claimWrap) begin
        bankFull[claimBank] <= 1'b1;
        claimBank           <= !claimBank;
      end
      if (resWrite) begin
        wrIdx <= writeWrap ? '0 : wrIdx + 1'b1;
      end
      if (writeWrap) begin
        bankDone[wrBank] <= 1'b1;
        wrBank           <= !wrBank;
      end
      if (pop) begin
        rdIdx <= drainWrap ? '0 : rdIdx + 1'b1;
      end
      if (drainWrap) begin
        bankDone[rdBank] <= 1'b0;
        bankFull[rdBank] <= 1'b0;
        rdBank           <= !rdBank;
      end
    end
  end
endmodule

// File: rtl/nde_datapath.sv
module nde_datapath
  import nde_pkg::*;
#(
  parameter int LANES = 32,
  parameter int NIB_W = 4,
  parameter int ACC_W = 48,
  parameter int RES_W = 16,
  parameter int REF_DEPTH = 32,
  parameter int BUF_DEPTH = 4,
  parameter int GROUP = 8,
  localparam int VEC_W = LANES * NIB_W,
  localparam int REF_AW = $clog2(REF_DEPTH),
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int SH_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refWe,
  input  logic [REF_AW-1:0] refAddr,
  input  logic [VEC_W-1:0]  refData,
  input  logic [VEC_W-1:0]  inData,
  input  logic [SH_W-1:0]   shiftAmt,
  input  strobe_t           strb,
  input  logic [REF_AW-1:0] chunkIdx,
  input  logic              wrBank,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              rdBank,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              resWrite,
  output logic [RES_W-1:0]  outData
);
  localparam int PROD_W = 2 * NIB_W;
  localparam int NGROUP = LANES / GROUP;
  localparam int GSUM_W = PROD_W + $clog2(GROUP);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (RES_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  // Reference memory: one write port, one read port
  logic [VEC_W-1:0] refMem [REF_DEPTH];
  logic [VEC_W-1:0] refRd;

  always_ff @(posedge clk) begin
    if (refWe) refMem[refAddr] <= refData;
  end
  assign refRd = refMem[chunkIdx];

  // Stage 1: unpack the nibbles and multiply in every lane
  logic [LANES*PROD_W-1:0] prodD;
  logic [LANES*PROD_W-1:0] prodQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] candExt;
    logic signed [PROD_W-1:0] refExt;
    assign candExt = PROD_W'($signed(inData[l*NIB_W +: NIB_W]));
    assign refExt  = PROD_W'($signed(refRd[l*NIB_W +: NIB_W]));
    assign prodD[l*PROD_W +: PROD_W] = candExt * refExt;
  end

  // Stage 2: sum the lane products group by group
  logic [NGROUP*GSUM_W-1:0] grpD;
  logic [NGROUP*GSUM_W-1:0] grpQ;

  for (genvar g = 0; g < NGROUP; g++) begin : g_group
    logic signed [GSUM_W-1:0] partial;
    always_comb begin
      partial = '0;
      for (int i = 0; i < GROUP; i++) begin
        partial = partial + GSUM_W'($signed(prodQ[(g*GROUP+i)*PROD_W +: PROD_W]));
      end
    end
    assign grpD[g*GSUM_W +: GSUM_W] = partial;
  end

  // Stage 3: final add into the wide accumulator
  logic signed [ACC_W-1:0] treeSum;
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    treeSum = '0;
    for (int g = 0; g < NGROUP; g++) begin
      treeSum = treeSum + ACC_W'($signed(grpQ[g*GSUM_W +: GSUM_W]));
    end
  end

  // Stage 4: shift, clamp, store in the result bank
  logic signed [ACC_W-1:0] shifted;
  logic [RES_W-1:0]        satVal;
  logic [RES_W-1:0]        bankMem [2][BUF_DEPTH];

  always_comb begin
    shifted = acc >>> shiftAmt;
    if (shifted > SAT_HI)      satVal = SAT_HI[RES_W-1:0];
    else if (shifted < SAT_LO) satVal = SAT_LO[RES_W-1:0];
    else                       satVal = shifted[RES_W-1:0];
  end

  logic s1Valid, s1First, s1Last;
  logic s2Valid, s2First, s2Last;
  logic s3Done;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0; s1First <= 1'b0; s1Last <= 1'b0;
      s2Valid <= 1'b0; s2First <= 1'b0; s2Last <= 1'b0;
      s3Done  <= 1'b0;
    end else begin
      s1Valid <= strb.take;
      s1First <= strb.first;
      s1Last  <= strb.last;
      s2Valid <= s1Valid;
      s2First <= s1First;
      s2Last  <= s1Last;
      s3Done  <= s2Valid && s2Last;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.take) prodQ <= prodD;
    if (s1Valid)   grpQ  <= grpD;
    if (s2Valid)   acc   <= s2First ? treeSum : acc + treeSum;
    if (s3Done)    bankMem[wrBank][wrIdx] <= satVal;
  end

  assign resWrite = s3Done;
  assign outData  = bankMem[rdBank][rdIdx];
endmodule

// File: rtl/nibbleDotEngine.sv
module nibbleDotEngine
  import nde_pkg::*;
#(
  parameter int LANES = 32,
  parameter int NIB_W = 4,
  parameter int ACC_W = 48,
  parameter int RES_W = 16,
  parameter int REF_DEPTH = 32,
  parameter int BUF_DEPTH = 4,
  parameter int GROUP = 8,
  localparam int VEC_W = LANES * NIB_W,
  localparam int REF_AW = $clog2(REF_DEPTH),
  localparam int SH_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refWe,
  input  logic [REF_AW-1:0] refAddr,
  input  logic [VEC_W-1:0]  refData,
  input  logic [REF_AW-1:0] vecChunksM1,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic              inValid,
  output logic              inReady,
  input  logic [VEC_W-1:0]  inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [RES_W-1:0]  outData,
  output logic              outBank
);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  strobe_t           strb;
  logic [REF_AW-1:0] chunkIdx;
  logic              wrBank;
  logic [IDX_W-1:0]  wrIdx;
  logic              rdBank;
  logic [IDX_W-1:0]  rdIdx;
  logic              resWrite;

  nde_ctrl #(
    .REF_DEPTH(REF_DEPTH),
    .BUF_DEPTH(BUF_DEPTH)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .vecChunksM1(vecChunksM1),
    .outReady(outReady), .resWrite(resWrite), .inReady(inReady), .strb(strb),
    .chunkIdx(chunkIdx), .wrBank(wrBank), .wrIdx(wrIdx), .rdBank(rdBank),
    .rdIdx(rdIdx), .outValid(outValid)
  );

  nde_datapath #(
    .LANES(LANES), .NIB_W(NIB_W), .ACC_W(ACC_W), .RES_W(RES_W),
    .REF_DEPTH(REF_DEPTH), .BUF_DEPTH(BUF_DEPTH), .GROUP(GROUP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .refWe(refWe), .refAddr(refAddr), .refData(refData),
    .inData(inData), .shiftAmt(shiftAmt), .strb(strb), .chunkIdx(chunkIdx),
    .wrBank(wrBank), .wrIdx(wrIdx), .rdBank(rdBank), .rdIdx(rdIdx),
    .resWrite(resWrite), .outData(outData)
  );

  assign outBank = rdBank;
endmodule

// File: rtl/nde_checker.sv
module nde_checker #(
  parameter int REF_AW = 5,
  parameter int RES_W = 16,
  parameter int BUF_DEPTH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [REF_AW-1:0] vecChunksM1,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [RES_W-1:0]  outData,
  input logic              outBank
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int PEND_W = $clog2(2 * BUF_DEPTH + 1) + 1;
  localparam logic [PEND_W-1:0] DEPTH_P = PEND_W'(BUF_DEPTH);
  localparam logic [PEND_W-1:0] CAP_P = PEND_W'(2 * BUF_DEPTH);

  logic [REF_AW-1:0] beatCnt;
  logic [PEND_W-1:0] pending;   // results claimed by accepted vectors, not yet popped
  logic [IDX_W-1:0]  popCnt;
  logic              expBank;
  logic              take, pop, vecEnd;

  assign take   = inValid && inReady;
  assign pop    = outValid && outReady;
  assign vecEnd = take && (beatCnt == vecChunksM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
      pending <= '0;
      popCnt  <= '0;
      expBank <= 1'b0;
    end else begin
      if (take) beatCnt <= vecEnd ? '0 : beatCnt + 1'b1;
      if (vecEnd && !pop)      pending <= pending + 1'b1;
      else if (!vecEnd && pop) pending <= pending - 1'b1;
      if (pop) begin
        popCnt <= popCnt + 1'b1;
        if (popCnt == IDX_W'(BUF_DEPTH - 1)) expBank <= !expBank;
      end
    end
  end

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outBank));

  p_bank_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> outBank == expBank);

  p_ready_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    pending <= DEPTH_P |-> inReady);

  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    pending <= CAP_P);

  p_full_bank_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && popCnt == '0 |-> pending >= DEPTH_P);
endmodule

bind nibbleDotEngine nde_checker #(
  .REF_AW(REF_AW), .RES_W(RES_W), .BUF_DEPTH(BUF_DEPTH)
) chk_i (
  .clk(clk), .rstN(rstN), .vecChunksM1(vecChunksM1), .inValid(inValid),
  .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outData(outData), .outBank(outBank)
);

// File: tb/nibbleDotEngine_tb_top.sv
`timescale 1ns/1ps
module nibbleDotEngine_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         refWe = 1'b0;
  logic [4:0]   refAddr = '0;
  logic [127:0] refData = '0;
  logic [4:0]   vecChunksM1 = '0;
  logic [5:0]   shiftAmt = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inData = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [15:0]  outData;
  logic         outBank;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  nibbleDotEngine dut_i (
    .clk(clk), .rstN(rstN), .refWe(refWe), .refAddr(refAddr), .refData(refData),
    .vecChunksM1(vecChunksM1), .shiftAmt(shiftAmt), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outBank(outBank)
  );

  // {refNib, candNib, chunksM1, shift, gaps, expected}
  localparam int NVEC = 8;
  localparam logic [35:0] VEC_TABLE [NVEC] = '{
    {4'h1, 4'h1, 5'd0,  6'd0, 1'b0, 16'd32},    // R2 R3 base case
    {4'hF, 4'h3, 5'd1,  6'd0, 1'b0, 16'hFF40},  // R2 -1*3*64 = -192
    {4'h7, 4'h7, 5'd3,  6'd2, 1'b1, 16'd1568},  // R3 R5 6272>>2 with gaps
    {4'h8, 4'h8, 5'd31, 6'd0, 1'b0, 16'h7FFF},  // R4 65536 clamps high
    {4'h8, 4'h7, 5'd31, 6'd0, 1'b1, 16'h8000},  // R4 -57344 clamps low
    {4'h8, 4'h8, 5'd31, 6'd4, 1'b0, 16'd4096},  // R3 wide sum kept, shift 4
    {4'h5, 4'hD, 5'd2,  6'd3, 1'b1, 16'hFF4C},  // R3 -1440>>>3 = -180
    {4'hD, 4'h1, 5'd0,  6'd6, 1'b0, 16'hFFFE}   // R3 -96>>>6 floors to -2
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendVector(input logic [127:0] refW, input logic [127:0] candW,
                            input int m1, input int sh, input bit gaps);
    repeat (6) @(negedge clk);
    vecChunksM1 = m1[4:0];
    shiftAmt    = sh[5:0];
    for (int k = 0; k <= m1; k++) begin
      refWe = 1'b1; refAddr = k[4:0]; refData = refW;
      @(negedge clk);
    end
    refWe = 1'b0;
    for (int k = 0; k <= m1; k++) begin
      inValid = 1'b1; inData = candW;
      while (!inReady) @(negedge clk);
      @(negedge clk);
      inValid = 1'b0;
      if (gaps) repeat (2) @(negedge clk);
    end
  endtask

  task automatic popCheck(input int exp, input bit bank, input string tag);
    @(negedge clk);
    while (!outValid) @(negedge clk);
    check($signed(outData) == exp, {tag, " data"}, $signed(outData), exp);
    check(outBank == bank, "R6 bank", int'(outBank), int'(bank));
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  function automatic logic [127:0] patRef();
    logic [127:0] w;
    for (int k = 0; k < 32; k++) w[4*k +: 4] = k[3:0];
    return w;
  endfunction

  function automatic logic [127:0] patCand();
    logic [127:0] w;
    for (int k = 0; k < 32; k++)
      w[4*k +: 4] = (k < 4) ? 4'h1 : ((k >= 8 && k < 16) ? 4'hF : 4'h0);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(outBank == 1'b0, "R1 outBank", int'(outBank), 0);

    // Table walk: eight vectors fill both banks
    for (int v = 0; v < NVEC; v++) begin
      sendVector({32{VEC_TABLE[v][35:32]}}, {32{VEC_TABLE[v][31:28]}},
                 int'(VEC_TABLE[v][27:23]), int'(VEC_TABLE[v][22:17]),
                 VEC_TABLE[v][16]);
    end
    repeat (8) @(negedge clk);

    // R8: both banks full, so a new beat must wait
    fork
      sendVector(patRef(), patCand(), 0, 0, 1'b0);
    join_none
    repeat (12) @(negedge clk);
    check(inReady == 1'b0, "R8 stall", int'(inReady), 0);

    // R7: offered result holds while not taken
    held = outData;
    repeat (3) @(negedge clk);
    check(outValid && outData == held, "R7 hold", int'(outData), int'(held));

    for (int v = 0; v < 4; v++)
      popCheck(int'($signed(VEC_TABLE[v][15:0])), 1'b0, "R3 R4 table");
    @(negedge clk);
    check(inReady == 1'b1, "R8 release", int'(inReady), 1);
    wait fork;
    for (int v = 4; v < NVEC; v++)
      popCheck(int'($signed(VEC_TABLE[v][15:0])), 1'b1, "R3 R4 R5 table");

    // R9: bank 0 holds one result only
    repeat (8) @(negedge clk);
    check(outValid == 1'b0, "R9 partial bank", int'(outValid), 0);

    sendVector({32{4'h2}}, {32{4'h2}}, 0, 0, 1'b0);
    sendVector({32{4'h1}}, {32{4'hF}}, 0, 0, 1'b0);
    sendVector({32{4'h0}}, {32{4'h5}}, 0, 0, 1'b0);
    popCheck(42, 1'b0, "R2 signed nibbles");
    popCheck(128, 1'b0, "R6 order");
    popCheck(-32, 1'b0, "R6 order");
    popCheck(0, 1'b0, "R6 order");
    @(negedge clk);
    check(outValid == 1'b0, "R6 drained", int'(outValid), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule